// File: doc/BRIEF.md
# Paged NIC Register File

This block is the register bank that a host processor sees when it drives a simple Ethernet controller over an 8-bit I/O bus with sixteen addresses. Address 0 always holds the command register. The two top bits of the command pick one of three register pages, and the other fifteen addresses map into that page. On page 0 a read and a write at the same address reach different registers. Page 1 holds the station address, the current receive page and the multicast mask. Page 2 gives read-only access to the page-0 setup registers that have no read path on page 0. Page 3 is invalid.

The bank holds the 16-bit transmit count, remote start address and remote byte count as byte halves. It keeps the interrupt status and mask registers and drives a level interrupt. It turns each command write into single-cycle pulses for the transmit and remote-DMA engines. Those engines report completion through a set vector that feeds the interrupt status register.

Top module: `nic_regbank`

## Requirements
- R1: After reset the command register reads 0x01 (stopped, page 0), the interrupt status reads 0x80 (only reset-complete, bit 7), the mask is 0x00 and `irq` is low.
- R2: Address 0 reads and writes the command register on every page, and command bits 7:6 select the page that addresses 1 to 15 decode (0, 1, 2; 3 is invalid).
- R3: On page 1, addresses 1 to 6 hold the station address bytes, address 7 holds the current receive page and addresses 8 to 15 hold the multicast mask bytes, all read back as written. The same addresses on page 0 reach other registers.
- R4: On page 0, a write to address 4 sets the transmit start page (`tx_page`), while a read of address 4 returns the `tx_stat` input.
- R5: Page 0 addresses 5/6, 8/9 and 10/11 write the low/high bytes of the transmit count, remote start address and remote byte count. Each write replaces only its own byte. Addresses 8/9 read back the remote start address.
- R6: Writing to page-0 address 7 clears each interrupt status bit where the data bit is 1. A hardware set (`hw_irq_set`) in the same cycle as a clear of the same bit leaves the bit set.
- R7: `irq` is high exactly when (status AND mask) is nonzero, and it follows the registers one cycle after any status or mask write. The mask is written at page-0 address 15.
- R8: A command write with start (bit 1) and remote read (bit 3) or remote write (bit 4) behaves in one of two ways. If the remote byte count is zero, it sets status bit 6 (remote-DMA complete) and emits no DMA pulse. Otherwise it gives a one-cycle `rdma_rd_go` or `rdma_wr_go` in the cycle after the write.
- R9: A command write with start (bit 1) and transmit (bit 2) gives a one-cycle `tx_go` in the cycle after the write. Transmit without start gives no pulse. Transmit-OK status (bit 1) is raised by the engine through `hw_irq_set`.
- R10: While page 3 is selected, writes to addresses 1 to 15 change nothing and reads of them return 0x00.
- R11: Page 2 reads back the ring start (1), ring stop (2), transmit start page (4), receive config (12), transmit config (13), data config (14) and mask (15). Writes to page 2 at addresses 1 to 15 are ignored.
- R12: A command write with bit 0 gives a one-cycle `stop_p`, and one with bit 1 gives a one-cycle `start_p`, each in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 8 | Read data, 0 when no read |
| tx_stat | input | 8 | Transmit status from the transmit engine |
| hw_irq_set | input | 8 | Per-bit interrupt status set requests |
| irq | output | 1 | Level interrupt |
| start_p | output | 1 | Start command pulse |
| stop_p | output | 1 | Stop command pulse |
| tx_go | output | 1 | Transmit request pulse |
| rdma_rd_go | output | 1 | Remote read request pulse |
| rdma_wr_go | output | 1 | Remote write request pulse |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |
| rdma_addr | output | 16 | Remote start address |
| rdma_count | output | 16 | Remote byte count |

## Verification
The hardest case to reach is a status clear and a hardware set landing on the same bit in the same clock. A bus write alone cannot produce it. The bench raises `hw_irq_set` in exactly the cycle of the write strobe to address 7, then reads the status back. The zero-count remote DMA case needs the byte count driven back to zero through its two halves first, so the bench builds the count up, checks each half, and then zeroes it before issuing the command.

// File: rtl/nic_regbank_pkg.sv
// Package: shared widths, command and status bit positions, page encoding.
package nic_regbank_pkg;
    localparam int DW        = 8;
    localparam int AW        = 4;
    localparam int STA_BYTES = 6;
    localparam int MC_BYTES  = 8;

    localparam int CMD_STOP  = 0;
    localparam int CMD_START = 1;
    localparam int CMD_XMIT  = 2;
    localparam int CMD_RRD   = 3;
    localparam int CMD_RWR   = 4;

    localparam int IS_RDC    = 6;
    localparam logic [DW-1:0] CMD_RESET = 8'h01;
    localparam logic [DW-1:0] ISR_RESET = 8'h80;

    typedef enum logic [1:0] {
        PG_LOW      = 2'd0,
        PG_STATION  = 2'd1,
        PG_READBACK = 2'd2,
        PG_BAD      = 2'd3
    } page_e;
endpackage

// File: rtl/nic_cmd_ctrl.sv
// Command register and command decode.
// Holds the command byte, exposes the selected page and turns each
// command write into registered one-cycle pulses. Assumes the caller
// asserts cmd_wr for a single cycle per bus write to address 0.
module nic_cmd_ctrl
    import nic_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [DW-1:0] wdata,
    input  logic          rcnt_zero,
    output logic [DW-1:0] cmd_q,
    output page_e         page,
    output logic          start_p,
    output logic          stop_p,
    output logic          tx_go,
    output logic          rd_go,
    output logic          wr_go,
    output logic          rdc_set
);
    logic dma_req;

    assign dma_req = wdata[CMD_START] & (wdata[CMD_RRD] | wdata[CMD_RWR]);
    assign rdc_set = cmd_wr & dma_req & rcnt_zero;
    assign page    = page_e'(cmd_q[DW-1:DW-2]);

    // Store the command and raise the pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_RESET;
            start_p <= 1'b0;
            stop_p  <= 1'b0;
            tx_go   <= 1'b0;
            rd_go   <= 1'b0;
            wr_go   <= 1'b0;
        end else begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
            tx_go   <= 1'b0;
            rd_go   <= 1'b0;
            wr_go   <= 1'b0;
            if (cmd_wr) begin
                cmd_q   <= wdata;
                stop_p  <= wdata[CMD_STOP];
                start_p <= wdata[CMD_START];
                tx_go   <= wdata[CMD_START] & wdata[CMD_XMIT];
                rd_go   <= wdata[CMD_START] & wdata[CMD_RRD] & ~rcnt_zero;
                wr_go   <= wdata[CMD_START] & wdata[CMD_RWR] & ~rcnt_zero;
            end
        end
    end
endmodule

// File: rtl/nic_irq_ctrl.sv
// Interrupt status and mask.
// Status bits are set by the set vector and cleared by writing ones;
// a set beats a clear of the same bit. The level output is derived
// combinationally from the two registers. Assumes the write enables
// are already qualified by page and address.
module nic_irq_ctrl
    import nic_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          isr_wr,
    input  logic          imr_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set_vec,
    output logic [DW-1:0] isr_q,
    output logic [DW-1:0] imr_q,
    output logic          irq
);
    logic [DW-1:0] clr_vec;

    assign clr_vec = isr_wr ? wdata : '0;
    assign irq     = |(isr_q & imr_q);

    // Update status (set wins over clear) and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= ISR_RESET;
            imr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~clr_vec) | set_vec;
            if (imr_wr) imr_q <= wdata;
        end
    end
endmodule

// File: rtl/nic_page_regs.sv
// Paged data registers and the read multiplexer.
// Stores the page-0 setup and count registers and the page-1 station
// registers, and selects read data by page and address. Assumes wr_en
// is already low for address 0 and for page 3.
module nic_page_regs
    import nic_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  page_e         page,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cmd_q,
    input  logic [DW-1:0] isr_q,
    input  logic [DW-1:0] imr_q,
    input  logic [DW-1:0] tx_stat,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] tx_page,
    output logic [2*DW-1:0] tx_count,
    output logic [2*DW-1:0] rdma_addr,
    output logic [2*DW-1:0] rdma_count
);
    localparam int CUR_ADDR = STA_BYTES + 1;
    localparam int MC_BASE  = STA_BYTES + 2;

    logic [DW-1:0] ring_start, ring_stop, bnd, rxcfg, txcfg, dcfg, cur_pg;
    logic [DW-1:0] sta [STA_BYTES];
    logic [DW-1:0] mc  [MC_BYTES];

    // Register writes for pages 0 and 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_start <= '0; ring_stop <= '0; bnd <= '0; tx_page <= '0;
            tx_count <= '0; rdma_addr <= '0; rdma_count <= '0;
            rxcfg <= '0; txcfg <= '0; dcfg <= '0; cur_pg <= '0;
            for (int i = 0; i < STA_BYTES; i++) sta[i] <= '0;
            for (int i = 0; i < MC_BYTES; i++) mc[i] <= '0;
        end else if (wr_en) begin
            case (page)
                PG_LOW: begin
                    case (addr)
                        4'h1: ring_start <= wdata;
                        4'h2: ring_stop  <= wdata;
                        4'h3: bnd        <= wdata;
                        4'h4: tx_page    <= wdata;
                        4'h5: tx_count[DW-1:0]     <= wdata;
                        4'h6: tx_count[2*DW-1:DW]  <= wdata;
                        4'h8: rdma_addr[DW-1:0]    <= wdata;
                        4'h9: rdma_addr[2*DW-1:DW] <= wdata;
                        4'hA: rdma_count[DW-1:0]   <= wdata;
                        4'hB: rdma_count[2*DW-1:DW] <= wdata;
                        4'hC: rxcfg <= wdata;
                        4'hD: txcfg <= wdata;
                        4'hE: dcfg  <= wdata;
                        default: ;
                    endcase
                end
                PG_STATION: begin
                    for (int i = 0; i < STA_BYTES; i++)
                        if (addr == AW'(i + 1)) sta[i] <= wdata;
                    if (addr == AW'(CUR_ADDR)) cur_pg <= wdata;
                    for (int i = 0; i < MC_BYTES; i++)
                        if (addr == AW'(MC_BASE + i)) mc[i] <= wdata;
                end
                default: ;
            endcase
        end
    end

    // Read data selection by page and address.
    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata = cmd_q;
        end else begin
            case (page)
                PG_LOW: begin
                    case (addr)
                        4'h3: rdata = bnd;
                        4'h4: rdata = tx_stat;
                        4'h7: rdata = isr_q;
                        4'h8: rdata = rdma_addr[DW-1:0];
                        4'h9: rdata = rdma_addr[2*DW-1:DW];
                        default: rdata = '0;
                    endcase
                end
                PG_STATION: begin
                    for (int i = 0; i < STA_BYTES; i++)
                        if (addr == AW'(i + 1)) rdata = sta[i];
                    if (addr == AW'(CUR_ADDR)) rdata = cur_pg;
                    for (int i = 0; i < MC_BYTES; i++)
                        if (addr == AW'(MC_BASE + i)) rdata = mc[i];
                end
                PG_READBACK: begin
                    case (addr)
                        4'h1: rdata = ring_start;
                        4'h2: rdata = ring_stop;
                        4'h4: rdata = tx_page;
                        4'hC: rdata = rxcfg;
                        4'hD: rdata = txcfg;
                        4'hE: rdata = dcfg;
                        4'hF: rdata = imr_q;
                        default: rdata = '0;
                    endcase
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/nic_regbank.sv
// Top of the paged register bank.
// Decodes bus strobes into command, status, mask and paged writes,
// merges completion requests into the status set vector and gates
// read data with the read strobe. Assumes one access per strobe cycle.
module nic_regbank
    import nic_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    tx_stat,
    input  logic [7:0]    hw_irq_set,
    output logic          irq,
    output logic          start_p,
    output logic          stop_p,
    output logic          tx_go,
    output logic          rdma_rd_go,
    output logic          rdma_wr_go,
    output logic [7:0]    tx_page,
    output logic [15:0]   tx_count,
    output logic [15:0]   rdma_addr,
    output logic [15:0]   rdma_count
);
    logic [DW-1:0] cmd_q, isr_q, imr_q, set_vec, mux_data;
    page_e         page;
    logic          cmd_wr, reg_wr, isr_wr, imr_wr, rdc_set;

    assign cmd_wr = bus_wr && (bus_addr == '0);
    assign reg_wr = bus_wr && (bus_addr != '0) && (page != PG_BAD);
    assign isr_wr = bus_wr && (page == PG_LOW) && (bus_addr == 4'h7);
    assign imr_wr = bus_wr && (page == PG_LOW) && (bus_addr == 4'hF);

    // Merge engine requests with the zero-count DMA completion.
    always_comb begin
        set_vec         = hw_irq_set;
        set_vec[IS_RDC] = hw_irq_set[IS_RDC] | rdc_set;
    end

    assign bus_rdata = bus_rd ? mux_data : '0;

    nic_cmd_ctrl u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(bus_wdata),
        .rcnt_zero(rdma_count == '0), .cmd_q(cmd_q), .page(page),
        .start_p(start_p), .stop_p(stop_p), .tx_go(tx_go),
        .rd_go(rdma_rd_go), .wr_go(rdma_wr_go), .rdc_set(rdc_set)
    );

    nic_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .isr_wr(isr_wr), .imr_wr(imr_wr),
        .wdata(bus_wdata), .set_vec(set_vec), .isr_q(isr_q),
        .imr_q(imr_q), .irq(irq)
    );

    nic_page_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .page(page),
        .addr(bus_addr), .wdata(bus_wdata), .cmd_q(cmd_q), .isr_q(isr_q),
        .imr_q(imr_q), .tx_stat(tx_stat), .rdata(mux_data),
        .tx_page(tx_page), .tx_count(tx_count), .rdma_addr(rdma_addr),
        .rdma_count(rdma_count)
    );
endmodule

// File: rtl/nic_regbank_chk.sv
// Checker for the register bank, bound to every instance of the top.
// Observes the bus, the status register and the command register.
module nic_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic [7:0]  hw_irq_set,
    input logic        irq,
    input logic [7:0]  cmd_q,
    input logic [7:0]  isr_q,
    input logic        tx_go,
    input logic        rdma_rd_go,
    input logic [7:0]  tx_page,
    input logic [15:0] tx_count,
    input logic [15:0] rdma_count
);
    // R1: reset loads command and status values.
    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> (cmd_q == 8'h01 && isr_q == 8'h80 && !irq));

    // R7: the interrupt only rises after a write or a set request.
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(bus_wr) || $past(hw_irq_set) != 8'h00));

    // R6: a set request always lands, whatever the bus does.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq_set != 8'h00 |=> (isr_q & $past(hw_irq_set)) == $past(hw_irq_set));

    // R8: zero-count DMA command raises remote-DMA complete.
    p_rdc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h0 && bus_wdata[1] && (bus_wdata[3] || bus_wdata[4])
         && rdma_count == 16'h0) |=> isr_q[6]);

    // R8: a remote read pulse comes only from a nonzero-count command.
    p_rd_go_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdma_rd_go |-> $past(bus_wr && bus_addr == 4'h0 && bus_wdata[1] && bus_wdata[3]
                             && rdma_count != 16'h0));

    // R9: a transmit pulse comes only from start with transmit.
    p_tx_go_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> $past(bus_wr && bus_addr == 4'h0 && bus_wdata[1] && bus_wdata[2]));

    // R10: writes on page 3 leave the data registers alone.
    p_page3_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cmd_q[7:6] == 2'b11 && bus_addr != 4'h0)
        |=> ($stable(tx_page) && $stable(tx_count) && $stable(rdma_count)));
endmodule

bind nic_regbank nic_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .hw_irq_set(hw_irq_set), .irq(irq), .cmd_q(cmd_q),
    .isr_q(isr_q), .tx_go(tx_go), .rdma_rd_go(rdma_rd_go), .tx_page(tx_page),
    .tx_count(tx_count), .rdma_count(rdma_count)
);

// File: tb/nic_regbank_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares.
module nic_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  tx_stat = '0;
    logic [7:0]  hw_irq_set = '0;
    logic        irq, start_p, stop_p, tx_go, rdma_rd_go, rdma_wr_go;
    logic [7:0]  tx_page;
    logic [15:0] tx_count, rdma_addr, rdma_count;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_stat(tx_stat), .hw_irq_set(hw_irq_set), .irq(irq),
        .start_p(start_p), .stop_p(stop_p), .tx_go(tx_go),
        .rdma_rd_go(rdma_rd_go), .rdma_wr_go(rdma_wr_go), .tx_page(tx_page),
        .tx_count(tx_count), .rdma_addr(rdma_addr), .rdma_count(rdma_count)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data at the falling edge of a read cycle.
    always @(negedge clk) begin
        if (bus_rd && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            chk({8'h00, bus_rdata}, {8'h00, it.exp}, it.tag);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic hwset(input logic [7:0] v);
        @(posedge clk); #1; hw_irq_set = v;
        @(posedge clk); #1; hw_irq_set = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, 8'h01, "R1 cmd");
        rd(4'h7, 8'h80, "R1 isr");
        chk({15'd0, irq}, 16'd0, "R1 irq");
        // R2 command on every page
        wr(4'h0, 8'h40); rd(4'h0, 8'h40, "R2 page1 cmd");
        wr(4'h0, 8'h80); rd(4'h0, 8'h80, "R2 page2 cmd");
        // R3 page 1 station registers
        wr(4'h0, 8'h40);
        for (int i = 1; i <= 6; i++) wr(4'(i), 8'hA0 + 8'(i));
        wr(4'h7, 8'h4C);
        for (int i = 8; i <= 15; i++) wr(4'(i), 8'hB0 + 8'(i));
        for (int i = 1; i <= 6; i++) rd(4'(i), 8'hA0 + 8'(i), "R3 station");
        rd(4'h7, 8'h4C, "R3 curpage");
        for (int i = 8; i <= 15; i++) rd(4'(i), 8'hB0 + 8'(i), "R3 mcast");
        wr(4'h0, 8'h00);
        rd(4'h5, 8'h00, "R3 page0 differs");
        // R4 read/write split at address 4
        wr(4'h4, 8'h2D);
        chk({8'h00, tx_page}, 16'h002D, "R4 tx_page");
        tx_stat = 8'h03;
        rd(4'h4, 8'h03, "R4 tx_stat read");
        // R5 byte halves
        wr(4'h5, 8'h3C); wr(4'h6, 8'h05); chk(tx_count, 16'h053C, "R5 tcnt");
        wr(4'h6, 8'h00); chk(tx_count, 16'h003C, "R5 tcnt hi only");
        wr(4'h8, 8'h34); wr(4'h9, 8'h12); chk(rdma_addr, 16'h1234, "R5 rsar");
        wr(4'h8, 8'hAB); chk(rdma_addr, 16'h12AB, "R5 rsar lo only");
        rd(4'h9, 8'h12, "R5 rsar hi read");
        wr(4'hA, 8'h10); wr(4'hB, 8'h02); chk(rdma_count, 16'h0210, "R5 rcnt");
        wr(4'hA, 8'h00); chk(rdma_count, 16'h0200, "R5 rcnt lo only");
        wr(4'hB, 8'h00); chk(rdma_count, 16'h0000, "R5 rcnt zero");
        // R8 zero-count remote read
        wr(4'h0, 8'h0A);
        chk({15'd0, rdma_rd_go}, 16'd0, "R8 no pulse at zero");
        rd(4'h7, 8'hC0, "R8 rdc set");
        wr(4'h7, 8'hFF); rd(4'h7, 8'h00, "R6 clear all");
        // R8 nonzero-count remote read and write
        wr(4'hA, 8'h20);
        wr(4'h0, 8'h0A);
        chk({15'd0, rdma_rd_go}, 16'd1, "R8 rd pulse");
        chk({15'd0, start_p}, 16'd1, "R12 start pulse");
        @(posedge clk); #1;
        chk({15'd0, rdma_rd_go}, 16'd0, "R8 rd pulse one cycle");
        rd(4'h7, 8'h00, "R8 no rdc");
        wr(4'h0, 8'h12);
        chk({15'd0, rdma_wr_go}, 16'd1, "R8 wr pulse");
        // R12 stop pulse
        wr(4'h0, 8'h01);
        chk({14'd0, stop_p, start_p}, 16'd2, "R12 stop only");
        @(posedge clk); #1;
        chk({15'd0, stop_p}, 16'd0, "R12 stop one cycle");
        // R9 transmit
        wr(4'h0, 8'h06);
        chk({15'd0, tx_go}, 16'd1, "R9 tx_go");
        chk({8'h00, tx_page}, 16'h002D, "R9 tx_page held");
        wr(4'h0, 8'h04);
        chk({15'd0, tx_go}, 16'd0, "R9 no start no tx");
        // R6 set beats clear
        hwset(8'h01);
        rd(4'h7, 8'h01, "R6 hw set");
        @(posedge clk); #1;
        bus_addr = 4'h7; bus_wdata = 8'h01; bus_wr = 1'b1; hw_irq_set = 8'h01;
        @(posedge clk); #1;
        bus_wr = 1'b0; hw_irq_set = '0;
        rd(4'h7, 8'h01, "R6 set wins");
        wr(4'h7, 8'h01); rd(4'h7, 8'h00, "R6 clear bit0");
        // R7 interrupt level
        hwset(8'h04);
        chk({15'd0, irq}, 16'd0, "R7 masked");
        wr(4'hF, 8'h04);
        chk({15'd0, irq}, 16'd1, "R7 unmasked");
        wr(4'h7, 8'h04);
        chk({15'd0, irq}, 16'd0, "R7 cleared");
        // R11 page 2 readback
        wr(4'h1, 8'h46); wr(4'h2, 8'h80); wr(4'hC, 8'h04);
        wr(4'h0, 8'h80);
        rd(4'h1, 8'h46, "R11 ring start");
        rd(4'h2, 8'h80, "R11 ring stop");
        rd(4'hC, 8'h04, "R11 rxcfg");
        rd(4'hF, 8'h04, "R11 imr");
        wr(4'h4, 8'h99);
        rd(4'h4, 8'h2D, "R11 page2 write ignored");
        // R10 page 3
        wr(4'h0, 8'hC0);
        wr(4'h4, 8'h77);
        chk({8'h00, tx_page}, 16'h002D, "R10 write ignored");
        rd(4'h4, 8'h00, "R10 read zero");
        rd(4'h0, 8'hC0, "R10 cmd visible");
        repeat (2) @(posedge clk);
        chk(16'(sb_q.size()), 16'd0, "scoreboard drained");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule